// File: doc/BRIEF.md
# Register Alias Table Renamer

This block renames the register operands of a stream of instructions. Architectural register numbers are mapped onto a larger set of physical registers that hold speculative results. Each instruction that writes a destination is given a physical register that no other live instruction holds. This removes write-after-write and write-after-read conflicts between instructions. A value's producer and all of its later readers end up naming the same physical register.

The front end presents one instruction per cycle on the rename port. It receives the physical names of the two sources, the new physical destination and the destination's previous physical name. It keeps that previous name with the instruction.

When the instruction retires in program order, the retire port writes the new mapping into a committed copy of the table and returns the previous name to the pool. A flush throws away all speculative mappings. It copies the committed table into the speculative one and rebuilds the pool from the physical registers the committed table does not reference.

Top module: `rat_renamer`

## Requirements
- R1: After reset, architectural register i maps to physical register i in both tables, and physical registers NUM_ARCH to NUM_PHYS-1 (16 to 31 by default) form the free pool.
- R2: The source outputs give the speculative mapping held before the instruction's own destination update. A source equal to the destination therefore returns the old name.
- R3: An accepted rename with a destination gets the lowest-numbered free physical register on `ren_pdst_o`. That register differs from the destination's previous name.
- R4: After an accepted rename, later readers of the destination get the newly allocated name, and that name leaves the free pool.
- R5: `ren_pold_o` gives the destination's mapping from before the rename.
- R6: A rename without a destination allocates nothing and leaves the table unchanged. It is accepted even when the pool is empty.
- R7: A rename with a destination is refused (`ren_ready_o` low) while the pool is empty, and changes no state.
- R8: A retire with a destination writes its mapping into the committed table and returns its old name to the pool. The returned name can be allocated from the following cycle, not in the retire cycle.
- R9: While `flush_i` is high, renames are refused. After the flush, the speculative table equals the committed table, including a retire made in the flush cycle. The pool then holds exactly the physical registers the committed table does not reference.
- R10: A cycle with `ren_valid_i` low changes neither the table nor the pool.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| ren_valid_i | input | 1 | Rename request present |
| ren_has_dst_i | input | 1 | Instruction writes a destination |
| ren_dst_i | input | 4 | Architectural destination |
| ren_src1_i | input | 4 | Architectural first source |
| ren_src2_i | input | 4 | Architectural second source |
| ren_ready_o | output | 1 | Request can be accepted this cycle |
| ren_psrc1_o | output | 5 | Physical first source |
| ren_psrc2_o | output | 5 | Physical second source |
| ren_pdst_o | output | 5 | Newly allocated physical destination |
| ren_pold_o | output | 5 | Previous physical name of the destination |
| ret_valid_i | input | 1 | Retire event present |
| ret_has_dst_i | input | 1 | Retiring instruction had a destination |
| ret_dst_i | input | 4 | Architectural destination of the retiring instruction |
| ret_pdst_i | input | 5 | Physical name it was given |
| ret_pold_i | input | 5 | Previous name to return to the pool |
| flush_i | input | 1 | Discard speculative mappings |

## Verification
The bench renames an instruction whose source equals its destination. A table that applied the update before the read would hand the reader its own new name and create a false self-dependency.

It drains the pool completely. A design that ignored the empty pool would hand out a name that is still live, or register 0 twice.

It retires into an empty pool while a rename waits. A bypass from release to allocation would accept that rename one cycle early.

It flushes in the same cycle as a retire. A design that restored from the committed table before applying the retire would lose that mapping. It would also leave a wrong pool size that the next allocation exposes.

// File: rtl/rat_pkg.sv
package rat_pkg;

    // Operation applied to the speculative table in one cycle.
    typedef enum logic [1:0] {
        MAP_HOLD    = 2'd0,
        MAP_WRITE   = 2'd1,
        MAP_RESTORE = 2'd2
    } map_op_e;

    // Index width for a set of n entries, never below one bit.
    function automatic int unsigned idx_w(input int unsigned n);
        return (n <= 1) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/rat_lowest_pick.sv
module rat_lowest_pick #(
    parameter  int unsigned WIDTH = 32,
    localparam int unsigned IW    = rat_pkg::idx_w(WIDTH)
) (
    input  logic [WIDTH-1:0] req_i,
    output logic             any_o,
    output logic [IW-1:0]    idx_o
);

    always_comb begin
        any_o = |req_i;
        idx_o = '0;
        // Scan downward so the lowest set bit is the last one written.
        for (int i = WIDTH - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                idx_o = IW'(i);
            end
        end
    end

endmodule

// File: rtl/rat_map_table.sv
module rat_map_table
    import rat_pkg::*;
#(
    parameter  int unsigned NUM_ARCH = 16,
    parameter  int unsigned NUM_PHYS = 32,
    localparam int unsigned AW       = idx_w(NUM_ARCH),
    localparam int unsigned PW       = idx_w(NUM_PHYS)
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic [AW-1:0]       rd_src1_i,
    input  logic [AW-1:0]       rd_src2_i,
    input  logic [AW-1:0]       rd_dst_i,
    output logic [PW-1:0]       rd_psrc1_o,
    output logic [PW-1:0]       rd_psrc2_o,
    output logic [PW-1:0]       rd_pold_o,
    input  map_op_e             op_i,
    input  logic [AW-1:0]       wr_arch_i,
    input  logic [PW-1:0]       wr_phys_i,
    input  logic                cm_en_i,
    input  logic [AW-1:0]       cm_arch_i,
    input  logic [PW-1:0]       cm_phys_i,
    output logic [NUM_PHYS-1:0] cm_used_o
);

    typedef logic [PW-1:0] phys_t;

    typedef struct packed {
        phys_t [NUM_ARCH-1:0] spec;
        phys_t [NUM_ARCH-1:0] comm;
    } map_st_t;

    map_st_t st_d, st_q;

    // Reads see the table as it stood before this cycle's update.
    assign rd_psrc1_o = st_q.spec[rd_src1_i];
    assign rd_psrc2_o = st_q.spec[rd_src2_i];
    assign rd_pold_o  = st_q.spec[rd_dst_i];

    always_comb begin
        st_d = st_q;
        if (cm_en_i) begin
            st_d.comm[cm_arch_i] = cm_phys_i;
        end
        unique case (op_i)
            MAP_WRITE:   st_d.spec[wr_arch_i] = wr_phys_i;
            MAP_RESTORE: st_d.spec = st_d.comm;
            default:     st_d.spec = st_q.spec;
        endcase
    end

    // Physical registers referenced by the next committed table.
    always_comb begin
        cm_used_o = '0;
        for (int i = 0; i < NUM_ARCH; i++) begin
            cm_used_o[st_d.comm[i]] = 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            for (int i = 0; i < NUM_ARCH; i++) begin
                st_q.spec[i] <= PW'(i);
                st_q.comm[i] <= PW'(i);
            end
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/rat_free_pool.sv
module rat_free_pool
    import rat_pkg::*;
#(
    parameter  int unsigned NUM_ARCH = 16,
    parameter  int unsigned NUM_PHYS = 32,
    localparam int unsigned PW       = idx_w(NUM_PHYS)
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                alloc_i,
    input  logic                rel_i,
    input  logic [PW-1:0]       rel_phys_i,
    input  logic                restore_i,
    input  logic [NUM_PHYS-1:0] restore_used_i,
    output logic                any_free_o,
    output logic [PW-1:0]       pick_o,
    output logic [NUM_PHYS-1:0] free_mask_o
);

    localparam logic [NUM_PHYS-1:0] RST_FREE = {NUM_PHYS{1'b1}} << NUM_ARCH;

    typedef struct packed {
        logic [NUM_PHYS-1:0] free;
    } pool_st_t;

    pool_st_t st_d, st_q;

    rat_lowest_pick #(
        .WIDTH (NUM_PHYS)
    ) u_pick (
        .req_i (st_q.free),
        .any_o (any_free_o),
        .idx_o (pick_o)
    );

    assign free_mask_o = st_q.free;

    always_comb begin
        st_d = st_q;
        if (restore_i) begin
            st_d.free = ~restore_used_i;
        end else begin
            if (rel_i) begin
                st_d.free[rel_phys_i] = 1'b1;
            end
            if (alloc_i) begin
                st_d.free[pick_o] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q.free <= RST_FREE;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/rat_renamer.sv
module rat_renamer
    import rat_pkg::*;
#(
    parameter  int unsigned NUM_ARCH = 16,
    parameter  int unsigned NUM_PHYS = 32,
    localparam int unsigned AW       = idx_w(NUM_ARCH),
    localparam int unsigned PW       = idx_w(NUM_PHYS)
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          ren_valid_i,
    input  logic          ren_has_dst_i,
    input  logic [AW-1:0] ren_dst_i,
    input  logic [AW-1:0] ren_src1_i,
    input  logic [AW-1:0] ren_src2_i,
    output logic          ren_ready_o,
    output logic [PW-1:0] ren_psrc1_o,
    output logic [PW-1:0] ren_psrc2_o,
    output logic [PW-1:0] ren_pdst_o,
    output logic [PW-1:0] ren_pold_o,
    input  logic          ret_valid_i,
    input  logic          ret_has_dst_i,
    input  logic [AW-1:0] ret_dst_i,
    input  logic [PW-1:0] ret_pdst_i,
    input  logic [PW-1:0] ret_pold_i,
    input  logic          flush_i
);

    logic                any_free;
    logic [PW-1:0]       pick;
    logic [PW-1:0]       pold_raw;
    logic [NUM_PHYS-1:0] cm_used;
    logic [NUM_PHYS-1:0] free_mask;
    logic                alloc;
    logic                ret_wr;
    map_op_e             map_op;

    assign ren_ready_o = !flush_i && (!ren_has_dst_i || any_free);
    assign alloc       = ren_valid_i && ren_ready_o && ren_has_dst_i;
    assign ret_wr      = ret_valid_i && ret_has_dst_i;

    always_comb begin
        if (flush_i) begin
            map_op = MAP_RESTORE;
        end else if (alloc) begin
            map_op = MAP_WRITE;
        end else begin
            map_op = MAP_HOLD;
        end
    end

    assign ren_pdst_o = ren_has_dst_i ? pick : '0;
    assign ren_pold_o = ren_has_dst_i ? pold_raw : '0;

    rat_map_table #(
        .NUM_ARCH (NUM_ARCH),
        .NUM_PHYS (NUM_PHYS)
    ) u_map (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .rd_src1_i  (ren_src1_i),
        .rd_src2_i  (ren_src2_i),
        .rd_dst_i   (ren_dst_i),
        .rd_psrc1_o (ren_psrc1_o),
        .rd_psrc2_o (ren_psrc2_o),
        .rd_pold_o  (pold_raw),
        .op_i       (map_op),
        .wr_arch_i  (ren_dst_i),
        .wr_phys_i  (pick),
        .cm_en_i    (ret_wr),
        .cm_arch_i  (ret_dst_i),
        .cm_phys_i  (ret_pdst_i),
        .cm_used_o  (cm_used)
    );

    rat_free_pool #(
        .NUM_ARCH (NUM_ARCH),
        .NUM_PHYS (NUM_PHYS)
    ) u_pool (
        .clk_i          (clk_i),
        .rst_ni         (rst_ni),
        .alloc_i        (alloc),
        .rel_i          (ret_wr),
        .rel_phys_i     (ret_pold_i),
        .restore_i      (flush_i),
        .restore_used_i (cm_used),
        .any_free_o     (any_free),
        .pick_o         (pick),
        .free_mask_o    (free_mask)
    );

endmodule

// File: rtl/rat_renamer_chk.sv
module rat_renamer_chk #(
    parameter  int unsigned NUM_ARCH = 16,
    parameter  int unsigned NUM_PHYS = 32,
    localparam int unsigned PW       = rat_pkg::idx_w(NUM_PHYS)
) (
    input logic                clk_i,
    input logic                rst_ni,
    input logic                ren_valid_i,
    input logic                ren_has_dst_i,
    input logic                ren_ready_o,
    input logic [PW-1:0]       ren_pdst_o,
    input logic [PW-1:0]       ren_pold_o,
    input logic                ret_valid_i,
    input logic                ret_has_dst_i,
    input logic [PW-1:0]       ret_pold_i,
    input logic                flush_i,
    input logic [NUM_PHYS-1:0] free_mask
);

    logic take;
    assign take = ren_valid_i && ren_ready_o && ren_has_dst_i;

    AST_PDST_FROM_POOL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        take |-> free_mask[ren_pdst_o]); // R3
    AST_PDST_NEW_NAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
        take |-> (ren_pdst_o != ren_pold_o)); // R3
    AST_ALLOC_LEAVES_POOL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        take |=> !free_mask[$past(ren_pdst_o)]); // R4
    AST_NODST_POOL_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!take && !ret_valid_i && !flush_i) |=> $stable(free_mask)); // R6
    AST_STALL_ON_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ren_has_dst_i && (free_mask == '0)) |-> !ren_ready_o); // R7
    AST_RETIRE_RELEASES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ret_valid_i && ret_has_dst_i && !flush_i) |=> free_mask[$past(ret_pold_i)]); // R8
    AST_FLUSH_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        flush_i |-> !ren_ready_o); // R9
    AST_FLUSH_POOL_SIZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        flush_i |=> ($countones(free_mask) == (NUM_PHYS - NUM_ARCH))); // R9

endmodule

bind rat_renamer rat_renamer_chk #(
    .NUM_ARCH (NUM_ARCH),
    .NUM_PHYS (NUM_PHYS)
) u_chk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .ren_valid_i   (ren_valid_i),
    .ren_has_dst_i (ren_has_dst_i),
    .ren_ready_o   (ren_ready_o),
    .ren_pdst_o    (ren_pdst_o),
    .ren_pold_o    (ren_pold_o),
    .ret_valid_i   (ret_valid_i),
    .ret_has_dst_i (ret_has_dst_i),
    .ret_pold_i    (ret_pold_i),
    .flush_i       (flush_i),
    .free_mask     (free_mask)
);

// File: tb/rat_renamer_tb_top.sv
`timescale 1ns/1ps
module rat_renamer_tb_top;

    localparam int NA = 16;
    localparam int NP = 32;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ren_valid = 1'b0, ren_has_dst = 1'b0;
    logic [3:0] ren_dst = '0, ren_src1 = '0, ren_src2 = '0;
    logic       ren_ready;
    logic [4:0] ren_psrc1, ren_psrc2, ren_pdst, ren_pold;
    logic       ret_valid = 1'b0, ret_has_dst = 1'b0;
    logic [3:0] ret_dst = '0;
    logic [4:0] ret_pdst = '0, ret_pold = '0;
    logic       flush = 1'b0;

    always #2.5 clk = ~clk;

    rat_renamer dut_i (
        .clk_i         (clk),
        .rst_ni        (rst_n),
        .ren_valid_i   (ren_valid),
        .ren_has_dst_i (ren_has_dst),
        .ren_dst_i     (ren_dst),
        .ren_src1_i    (ren_src1),
        .ren_src2_i    (ren_src2),
        .ren_ready_o   (ren_ready),
        .ren_psrc1_o   (ren_psrc1),
        .ren_psrc2_o   (ren_psrc2),
        .ren_pdst_o    (ren_pdst),
        .ren_pold_o    (ren_pold),
        .ret_valid_i   (ret_valid),
        .ret_has_dst_i (ret_has_dst),
        .ret_dst_i     (ret_dst),
        .ret_pdst_i    (ret_pdst),
        .ret_pold_i    (ret_pold),
        .flush_i       (flush)
    );

    typedef struct {
        int d;
        int p;
        int o;
    } inflight_t;

    int        checks = 0;
    int        fails = 0;
    bit        done = 1'b0;
    int        spec_m[NA];
    int        comm_m[NA];
    bit        free_m[NP];
    inflight_t q[$];
    int        last_ready, last_psrc1, last_psrc2, last_pdst, last_pold;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit any_free();
        for (int i = 0; i < NP; i++) if (free_m[i]) return 1'b1;
        return 1'b0;
    endfunction

    function automatic int low_free();
        for (int i = 0; i < NP; i++) if (free_m[i]) return i;
        return 0;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < NA; i++) begin
            spec_m[i] = i;
            comm_m[i] = i;
        end
        for (int i = 0; i < NP; i++) free_m[i] = (i >= NA);
        q.delete();
    endtask

    // One cycle: drive after the falling edge, compare, then advance the model at the rising edge.
    task automatic step(input bit v, input bit hd, input int d, input int s1, input int s2,
                        input bit rv, input bit fl);
        bit        have_ret;
        bit        exp_ready;
        bit        fire;
        int        newp;
        inflight_t e;
        have_ret = rv && (q.size() > 0);
        if (have_ret) e = q[0];
        ren_valid   = v;
        ren_has_dst = hd;
        ren_dst     = 4'(d);
        ren_src1    = 4'(s1);
        ren_src2    = 4'(s2);
        flush       = fl;
        ret_valid   = have_ret;
        ret_has_dst = have_ret;
        ret_dst     = have_ret ? 4'(e.d) : 4'd0;
        ret_pdst    = have_ret ? 5'(e.p) : 5'd0;
        ret_pold    = have_ret ? 5'(e.o) : 5'd0;
        #1;
        exp_ready = !fl && (!hd || any_free());
        last_ready = int'(ren_ready);
        last_psrc1 = int'(ren_psrc1);
        last_psrc2 = int'(ren_psrc2);
        last_pdst  = int'(ren_pdst);
        last_pold  = int'(ren_pold);
        chk(fl ? "R9" : "R7", last_ready, int'(exp_ready));
        chk("R2", last_psrc1, spec_m[s1]);
        chk("R4", last_psrc2, spec_m[s2]);
        if (hd) begin
            chk("R5", last_pold, spec_m[d]);
            if (exp_ready) chk("R3", last_pdst, low_free());
        end
        fire = v && exp_ready;
        newp = low_free();
        @(posedge clk);
        if (fl) begin
            if (have_ret) comm_m[e.d] = e.p;
            for (int i = 0; i < NA; i++) spec_m[i] = comm_m[i];
            for (int i = 0; i < NP; i++) free_m[i] = 1'b1;
            for (int i = 0; i < NA; i++) free_m[comm_m[i]] = 1'b0;
            q.delete();
        end else begin
            if (have_ret) begin
                comm_m[e.d] = e.p;
                free_m[e.o] = 1'b1;
                void'(q.pop_front());
            end
            if (fire && hd) begin
                q.push_back('{d: d, p: newp, o: spec_m[d]});
                spec_m[d] = newp;
                free_m[newp] = 1'b0;
            end
        end
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: identity mapping after reset
        for (int i = 0; i < NA; i++) begin
            step(1, 0, 0, i, i, 0, 0);
            chk("R1", last_psrc1, i);
        end

        // R10: idle cycle with a destination present consumes nothing
        step(0, 1, 3, 0, 0, 0, 0);
        step(1, 1, 3, 3, 0, 0, 0);
        chk("R10", last_pdst, 16);
        chk("R1", last_pdst, 16);
        chk("R5", last_pold, 3);
        chk("R2", last_psrc1, 3);
        step(1, 0, 0, 3, 3, 0, 0);
        chk("R4", last_psrc1, 16);

        // R6: no destination, no allocation
        step(1, 0, 5, 5, 5, 0, 0);
        step(1, 1, 5, 0, 0, 0, 0);
        chk("R6", last_pdst, 17);

        // Drain the pool: 18..31
        for (int i = 0; i < 14; i++) begin
            step(1, 1, 0, 0, 0, 0, 0);
            chk("R3", last_pdst, 18 + i);
        end
        step(1, 1, 1, 0, 0, 0, 0);
        chk("R7", last_ready, 0);
        step(1, 1, 1, 1, 1, 0, 0);
        chk("R7", last_psrc1, 1);
        step(1, 0, 1, 0, 0, 0, 0);
        chk("R6", last_ready, 1);

        // R8: retire frees name 3, usable next cycle only
        step(1, 1, 2, 0, 0, 1, 0);
        chk("R8", last_ready, 0);
        step(1, 1, 2, 0, 0, 0, 0);
        chk("R8", last_ready, 1);
        chk("R8", last_pdst, 3);

        // R9: flush with a retire in the same cycle
        step(1, 0, 0, 0, 0, 1, 1);
        chk("R9", last_ready, 0);
        step(1, 0, 0, 5, 3, 0, 0);
        chk("R9", last_psrc1, 17);
        chk("R9", last_psrc2, 16);
        step(1, 1, 0, 0, 0, 0, 0);
        chk("R9", last_pdst, 3);

        // Mixed traffic against the model
        for (int n = 0; n < 3000; n++) begin
            bit rv;
            rv = (q.size() > 0) && (($urandom % 3 == 0) || (q.size() > 14));
            step(($urandom % 4) != 0, ($urandom % 4) != 0, int'($urandom % NA),
                 int'($urandom % NA), int'($urandom % NA), rv, ($urandom % 128) == 0);
        end

        finish_run();
    end

endmodule